// File: doc/BRIEF.md
# SWD Transfer Retry and Recovery Controller

This controller turns single register commands from a debug command port into a sequence of packets for a serial-wire packet engine, and decides what to do with each acknowledge the engine returns. A debug-port (DP) access is one packet. An access-port (AP) read is posted, so it is followed by a DP read of the read-buffer register, and the data of that second packet is the result. A WAIT acknowledge makes the controller reissue the same packet until a cycle budget counted from command accept runs out.

A FAULT acknowledge starts a recovery routine. The controller reads the DP control/status register, turns every sticky error flag it finds there into the matching clear bit, writes those bits to the DP abort register in one packet, and then replays the failed packet once. If the replay also faults, a fault flag is latched and the command ends with zero data. While that flag is set, AP commands finish at once with zero data and produce no packet. DP commands still run, and a later recovery routine clears the flag. Every command ends with one result strobe that carries the data and a status code for success, fault, timeout, protocol error or parity error.

The bit-level serialisation belongs to the packet engine. This block only produces the 8-bit request header and the write word, and it consumes the acknowledge, the read word and the engine's parity verdict.

Top module: `swd_xfer_ctrl`

## Requirements
- R1: Each packet carries an 8-bit header: bit0 start = 1, bit1 = AP select, bit2 = read, bit3 = address bit 2, bit4 = address bit 3, bit5 = even parity over bits 1 to 4, bit6 stop = 0, bit7 park = 1. The address bits are the 2-bit register select.
- R2: A DP command whose packet is acknowledged OK (ack code 3'b001) ends with status OK (code 0). A read returns the packet's read word, and a write presents the command's write word on pkt_wdata and returns zero.
- R3: An AP read whose packet is acknowledged OK is followed by a DP read of register select 3, the read buffer. The result is the data of that second packet.
- R4: A WAIT acknowledge (3'b010) makes the controller reissue the same header and write word in a new packet.
- R5: A WAIT that arrives once TIMEOUT_CYCLES cycles have passed since command accept ends the command with status TIMEOUT (code 2) and zero data.
- R6: A FAULT acknowledge (3'b100) on a packet that is not a replay is followed by a DP read of register select 1 (control/status), then a DP write to register select 0 (abort), then a replay of the faulted packet.
- R7: The abort write sets bit 4 for status bit 1, bit 1 for status bit 4, bit 2 for status bit 5 and bit 3 for status bit 7. All other bits are zero, and the value is zero if the status read was not OK or failed parity. The fault flag is cleared by the abort write.
- R8: A FAULT on the replay packet sets fault_flag and ends the command with status FAULT (code 1) and zero data.
- R9: While fault_flag is set, an AP command gets its result strobe in the cycle after accept, with status FAULT, zero data and no packet. DP commands still run normally.
- R10: Any acknowledge other than the three codes above ends the command with status PROTOCOL (code 3) and zero data.
- R11: A read packet that is acknowledged OK but flagged with a parity error ends the command at once with status PARITY (code 4) and zero data.
- R12: busy rises in the cycle after accept and stays high through the single-cycle rsp_valid strobe. pkt_req is only high while busy. cmd_valid has no effect while busy.
- R13: After reset busy, rsp_valid, pkt_req and fault_flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered; taken when idle |
| cmd_ap | input | 1 | 1 = access port, 0 = debug port |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | 2 | Register select (address bits 3:2) |
| cmd_wdata | input | DATA_W | Write word |
| busy | output | 1 | Command in progress |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_data | output | DATA_W | Result data |
| rsp_status | output | 3 | 0 OK, 1 FAULT, 2 TIMEOUT, 3 PROTOCOL, 4 PARITY |
| fault_flag | output | 1 | Latched fault that blocks AP commands |
| pkt_req | output | 1 | One-cycle packet request to the engine |
| pkt_header | output | 8 | Request header of the packet |
| pkt_wdata | output | DATA_W | Write word of the packet |
| pkt_done | input | 1 | Engine finished the packet |
| pkt_ack | input | 3 | Acknowledge code |
| pkt_rdata | input | DATA_W | Read word from the engine |
| pkt_parity_err | input | 1 | Parity of the read word was wrong |

## Verification
The bench builds the controller with a 32-bit data word and TIMEOUT_CYCLES set to 48. With that budget a run of WAIT acknowledges reaches the timeout path within a few dozen cycles, while short scripted WAIT bursts of two or three packets finish well before it. The packet engine is scripted to respond two cycles after each request. This puts the full recovery routine, a replay that faults again, the blocked AP path and the posted read-buffer follow-up within a short run, and each command's header sequence and result are compared against a behavioural model.

// File: rtl/swd_xfer_pkg.sv
package swd_xfer_pkg;

    typedef enum logic [2:0] {
        ST_OK      = 3'd0,
        ST_FAULT   = 3'd1,
        ST_TIMEOUT = 3'd2,
        ST_PROTO   = 3'd3,
        ST_PARITY  = 3'd4
    } status_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_REQ,
        S_RSP,
        S_DONE
    } state_e;

    // which packet of a command is in flight
    typedef enum logic [1:0] {
        PH_MAIN,
        PH_RDBUF,
        PH_CLR_RD,
        PH_CLR_WR
    } phase_e;

    localparam logic [2:0] ACK_OK    = 3'b001;
    localparam logic [2:0] ACK_WAIT  = 3'b010;
    localparam logic [2:0] ACK_FAULT = 3'b100;

    localparam logic [1:0] SEL_ABORT    = 2'd0;
    localparam logic [1:0] SEL_CTRLSTAT = 2'd1;
    localparam logic [1:0] SEL_RDBUF    = 2'd3;

    // sticky flag positions in the status word
    localparam int STK_OVERRUN = 1;
    localparam int STK_COMPARE = 4;
    localparam int STK_ERROR   = 5;
    localparam int STK_WDATA   = 7;

    // matching clear positions in the abort word
    localparam int CLR_COMPARE = 1;
    localparam int CLR_ERROR   = 2;
    localparam int CLR_WDATA   = 3;
    localparam int CLR_OVERRUN = 4;

    localparam int STK_W = 8;

endpackage

// File: rtl/swd_sticky_map.sv
module swd_sticky_map
    import swd_xfer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [STK_W-1:0]  ctrlstat,
    input  logic              valid,
    output logic [DATA_W-1:0] abort_val
);

    localparam int NMAP = 4;

    // pair table: sticky position -> clear position
    function automatic int stk_pos(input int i);
        case (i)
            0:       return STK_OVERRUN;
            1:       return STK_COMPARE;
            2:       return STK_ERROR;
            default: return STK_WDATA;
        endcase
    endfunction

    function automatic int clr_pos(input int i);
        case (i)
            0:       return CLR_OVERRUN;
            1:       return CLR_COMPARE;
            2:       return CLR_ERROR;
            default: return CLR_WDATA;
        endcase
    endfunction

    logic [NMAP-1:0] hit;

    generate
        for (genvar g = 0; g < NMAP; g++) begin : g_map
            assign hit[g] = valid & ctrlstat[stk_pos(g)];
        end
    endgenerate

    always_comb begin
        abort_val = '0;
        for (int i = 0; i < NMAP; i++) begin
            abort_val[clr_pos(i)] = hit[i];
        end
    end

endmodule

// File: rtl/swd_req_builder.sv
module swd_req_builder
    import swd_xfer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  phase_e            phase,
    input  logic              cmd_ap,
    input  logic              cmd_read,
    input  logic [1:0]        cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [DATA_W-1:0] abort_val,
    output logic [7:0]        header,
    output logic [DATA_W-1:0] wdata,
    output logic              xfer_read
);

    logic       sel_ap;
    logic [1:0] sel_addr;

    always_comb begin
        sel_ap    = 1'b0;
        xfer_read = 1'b1;
        sel_addr  = cmd_addr;
        wdata     = '0;
        case (phase)
            PH_MAIN: begin
                sel_ap    = cmd_ap;
                xfer_read = cmd_read;
                if (!cmd_read) wdata = cmd_wdata;
            end
            PH_RDBUF:  sel_addr = SEL_RDBUF;
            PH_CLR_RD: sel_addr = SEL_CTRLSTAT;
            default: begin
                sel_addr  = SEL_ABORT;
                xfer_read = 1'b0;
                wdata     = abort_val;
            end
        endcase
        header = {1'b1, 1'b0, ^{sel_ap, xfer_read, sel_addr},
                  sel_addr[1], sel_addr[0], xfer_read, sel_ap, 1'b1};
    end

endmodule

// File: rtl/swd_wait_timer.sv
module swd_wait_timer #(
    parameter int LIMIT = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expired
);

    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign expired = (cnt_q >= CNT_W'(LIMIT));

    always_comb begin
        cnt_d = cnt_q;
        if (restart)       cnt_d = '0;
        else if (!expired) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5: once expired the budget stays spent until the next command
    p_expiry_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !restart) |=> expired);

endmodule

// File: rtl/swd_xfer_ctrl.sv
module swd_xfer_ctrl
    import swd_xfer_pkg::*;
#(
    parameter int DATA_W         = 32,
    parameter int TIMEOUT_CYCLES = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_ap,
    input  logic              cmd_read,
    input  logic [1:0]        cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              busy,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [2:0]        rsp_status,
    output logic              fault_flag,
    output logic              pkt_req,
    output logic [7:0]        pkt_header,
    output logic [DATA_W-1:0] pkt_wdata,
    input  logic              pkt_done,
    input  logic [2:0]        pkt_ack,
    input  logic [DATA_W-1:0] pkt_rdata,
    input  logic              pkt_parity_err
);

    typedef struct packed {
        state_e            st;
        phase_e            ph;
        phase_e            ret;
        logic              replay;
        logic              fault;
        logic              ap;
        logic              rd;
        logic [1:0]        addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] clrv;
        logic [DATA_W-1:0] data;
        status_e           status;
    } ctl_t;

    ctl_t q, d;

    logic              restart;
    logic              expired;
    logic              xfer_read;
    logic [DATA_W-1:0] abort_map;
    logic              stat_good;

    assign stat_good = (pkt_ack == ACK_OK) && !pkt_parity_err;

    swd_sticky_map #(.DATA_W(DATA_W)) u_map (
        .ctrlstat  (pkt_rdata[STK_W-1:0]),
        .valid     (stat_good),
        .abort_val (abort_map)
    );

    swd_req_builder #(.DATA_W(DATA_W)) u_build (
        .phase     (q.ph),
        .cmd_ap    (q.ap),
        .cmd_read  (q.rd),
        .cmd_addr  (q.addr),
        .cmd_wdata (q.wdata),
        .abort_val (q.clrv),
        .header    (pkt_header),
        .wdata     (pkt_wdata),
        .xfer_read (xfer_read)
    );

    swd_wait_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .expired (expired)
    );

    always_comb begin
        d       = q;
        restart = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (cmd_valid) begin
                    restart  = 1'b1;
                    d.ap     = cmd_ap;
                    d.rd     = cmd_read;
                    d.addr   = cmd_addr;
                    d.wdata  = cmd_wdata;
                    d.ph     = PH_MAIN;
                    d.replay = 1'b0;
                    d.data   = '0;
                    if (cmd_ap && q.fault) begin
                        d.status = ST_FAULT;
                        d.st     = S_DONE;
                    end else begin
                        d.status = ST_OK;
                        d.st     = S_REQ;
                    end
                end
            end
            S_REQ: d.st = S_RSP;
            S_RSP: begin
                if (pkt_done) begin
                    d.data = '0;
                    case (q.ph)
                        PH_CLR_RD: begin
                            d.clrv = abort_map;
                            d.ph   = PH_CLR_WR;
                            d.st   = S_REQ;
                        end
                        PH_CLR_WR: begin
                            d.fault  = 1'b0;
                            d.ph     = q.ret;
                            d.replay = 1'b1;
                            d.st     = S_REQ;
                        end
                        default: begin
                            if (pkt_ack == ACK_OK) begin
                                if (xfer_read && pkt_parity_err) begin
                                    d.status = ST_PARITY;
                                    d.st     = S_DONE;
                                end else if (q.ph == PH_MAIN && q.ap && q.rd) begin
                                    d.ph     = PH_RDBUF;
                                    d.replay = 1'b0;
                                    d.st     = S_REQ;
                                end else begin
                                    d.status = ST_OK;
                                    d.data   = xfer_read ? pkt_rdata : '0;
                                    d.st     = S_DONE;
                                end
                            end else if (pkt_ack == ACK_WAIT) begin
                                if (expired) begin
                                    d.status = ST_TIMEOUT;
                                    d.st     = S_DONE;
                                end else begin
                                    d.replay = 1'b0;
                                    d.st     = S_REQ;
                                end
                            end else if (pkt_ack == ACK_FAULT) begin
                                if (q.replay) begin
                                    d.fault  = 1'b1;
                                    d.status = ST_FAULT;
                                    d.st     = S_DONE;
                                end else begin
                                    d.ret = q.ph;
                                    d.ph  = PH_CLR_RD;
                                    d.st  = S_REQ;
                                end
                            end else begin
                                d.status = ST_PROTO;
                                d.st     = S_DONE;
                            end
                        end
                    endcase
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= S_IDLE;
            q.ph     <= PH_MAIN;
            q.ret    <= PH_MAIN;
            q.status <= ST_OK;
        end else begin
            q <= d;
        end
    end

    assign busy       = (q.st != S_IDLE);
    assign rsp_valid  = (q.st == S_DONE);
    assign rsp_data   = q.data;
    assign rsp_status = q.status;
    assign fault_flag = q.fault;
    assign pkt_req    = (q.st == S_REQ);

    // R12: the engine is only driven inside a command
    p_req_in_cmd_r12: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_req |-> busy);

    // R12: result strobe lasts one cycle and ends the command
    p_rsp_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && !busy));

    // R4: a WAIT inside budget reissues the identical header
    p_wait_reissue_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_RSP && pkt_done && pkt_ack == ACK_WAIT && !expired &&
         (q.ph == PH_MAIN || q.ph == PH_RDBUF))
        |=> (pkt_req && pkt_header == $past(pkt_header)));

    // R3: an accepted AP read is chased by a read-buffer read (header 0xBD)
    p_rdbuf_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_RSP && pkt_done && pkt_ack == ACK_OK && !pkt_parity_err &&
         q.ph == PH_MAIN && q.ap && q.rd)
        |=> (pkt_req && pkt_header == 8'hBD));

    // R6: a first FAULT goes to the status read (header 0x8D)
    p_fault_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_RSP && pkt_done && pkt_ack == ACK_FAULT && !q.replay &&
         (q.ph == PH_MAIN || q.ph == PH_RDBUF))
        |=> (pkt_req && pkt_header == 8'h8D));

    // R8: the fault flag only rises together with a FAULT result of zero
    p_fault_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_flag) |-> (rsp_valid && rsp_status == 3'd1 && rsp_data == '0));

    // R9: a blocked AP command gives an immediate result and no packet
    p_ap_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && cmd_ap && fault_flag)
        |=> (rsp_valid && !pkt_req && rsp_status == 3'd1));

    // R11: a parity error on read data ends the command next cycle
    p_parity_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_RSP && pkt_done && pkt_ack == ACK_OK && pkt_parity_err &&
         xfer_read && (q.ph == PH_MAIN || q.ph == PH_RDBUF))
        |=> (rsp_valid && rsp_status == 3'd4));

    // R5: timeout status only with the budget spent
    p_timeout_late_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 3'd2) |-> expired);

endmodule

// File: tb/swd_xfer_ctrl_test.sv
module swd_xfer_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 32;
    localparam int TMO        = 48;
    localparam int LAT        = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0, cmd_ap = 1'b0, cmd_read = 1'b0;
    logic [1:0]    cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          busy, rsp_valid, fault_flag, pkt_req;
    logic [DW-1:0] rsp_data, pkt_wdata;
    logic [2:0]    rsp_status;
    logic [7:0]    pkt_header;
    logic          pkt_done = 1'b0, pkt_parity_err = 1'b0;
    logic [2:0]    pkt_ack = '0;
    logic [DW-1:0] pkt_rdata = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    swd_xfer_ctrl #(.DATA_W(DW), .TIMEOUT_CYCLES(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ap(cmd_ap),
        .cmd_read(cmd_read), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_status(rsp_status), .fault_flag(fault_flag), .pkt_req(pkt_req),
        .pkt_header(pkt_header), .pkt_wdata(pkt_wdata), .pkt_done(pkt_done),
        .pkt_ack(pkt_ack), .pkt_rdata(pkt_rdata), .pkt_parity_err(pkt_parity_err)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // scripted engine responses (engine copy and model copy)
    logic [2:0]    e_ack[$], m_ack[$];
    logic [DW-1:0] e_rd[$],  m_rd[$];
    bit            e_pe[$],  m_pe[$];
    logic [7:0]    obs_hdr[$], exp_hdr[$];
    logic [DW-1:0] obs_wd[$],  exp_wd[$];
    logic [DW-1:0] exp_data;
    logic [2:0]    exp_status;
    bit            m_fault = 0;

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [7:0] mk_hdr(input bit ap, input bit rd, input bit [1:0] a);
        return {1'b1, 1'b0, ap ^ rd ^ a[0] ^ a[1], a[1], a[0], rd, ap, 1'b1};
    endfunction

    function automatic logic [DW-1:0] clear_word(input logic [DW-1:0] s);
        logic [DW-1:0] c = '0;
        c[4] = s[1];
        c[1] = s[4];
        c[2] = s[5];
        c[3] = s[7];
        return c;
    endfunction

    task automatic resp(input logic [2:0] a, input logic [DW-1:0] r, input bit pe);
        e_ack.push_back(a); m_ack.push_back(a);
        e_rd.push_back(r);  m_rd.push_back(r);
        e_pe.push_back(pe); m_pe.push_back(pe);
    endtask

    task automatic pop_m(output logic [2:0] a, output logic [DW-1:0] r, output bit pe);
        if (m_ack.size() == 0) begin a = 3'b010; r = '0; pe = 0; end
        else begin a = m_ack.pop_front(); r = m_rd.pop_front(); pe = m_pe.pop_front(); end
    endtask

    // behavioural reference: walks the response script packet by packet
    task automatic model(input bit ap, input bit rd, input bit [1:0] a, input logic [DW-1:0] wd);
        bit cap = ap, crd = rd, replay = 0, second = 0, done = 0;
        bit [1:0] ca = a;
        logic [DW-1:0] cwd = rd ? '0 : wd;
        logic [2:0] k; logic [DW-1:0] r; bit pe;
        exp_hdr.delete(); exp_wd.delete();
        exp_data = '0;
        if (ap && m_fault) begin exp_status = 3'd1; return; end
        for (int guard = 0; guard < 64 && !done; guard++) begin
            exp_hdr.push_back(mk_hdr(cap, crd, ca)); exp_wd.push_back(cwd);
            pop_m(k, r, pe);
            if (k == 3'b001) begin
                if (crd && pe) begin exp_status = 3'd4; done = 1; end
                else if (!second && cap && crd) begin
                    second = 1; cap = 0; ca = 2'd3; replay = 0;
                end else begin
                    exp_status = 3'd0; exp_data = crd ? r : '0; done = 1;
                end
            end else if (k == 3'b010) begin
                replay = 0;
            end else if (k == 3'b100) begin
                if (replay) begin m_fault = 1; exp_status = 3'd1; done = 1; end
                else begin
                    logic [DW-1:0] cw;
                    exp_hdr.push_back(mk_hdr(0, 1, 2'd1)); exp_wd.push_back('0);
                    pop_m(k, r, pe);
                    cw = (k == 3'b001 && !pe) ? clear_word(r) : '0;
                    exp_hdr.push_back(mk_hdr(0, 0, 2'd0)); exp_wd.push_back(cw);
                    pop_m(k, r, pe);
                    m_fault = 0; replay = 1;
                end
            end else begin
                exp_status = 3'd3; done = 1;
            end
        end
    endtask

    // packet engine: answers LAT cycles after each request
    initial forever begin
        @(negedge clk);
        pkt_done = 1'b0;
        if (rst_n && pkt_req) begin
            obs_hdr.push_back(pkt_header);
            obs_wd.push_back(pkt_wdata);
            repeat (LAT) @(negedge clk);
            if (e_ack.size() == 0) begin
                pkt_ack = 3'b010; pkt_rdata = '0; pkt_parity_err = 1'b0;
            end else begin
                pkt_ack = e_ack.pop_front(); pkt_rdata = e_rd.pop_front();
                pkt_parity_err = e_pe.pop_front();
            end
            pkt_done = 1'b1;
        end
    end

    // every-clock comparison of the handshake outputs (R12)
    initial forever begin
        @(negedge clk);
        if (rst_n && !finished) begin
            chk(!((pkt_req || rsp_valid) && !busy), "R12 activity outside busy",
                {30'd0, pkt_req, rsp_valid}, 32'd0);
        end
    end

    // issue one command; returns the cycles from accept to result
    task automatic issue(input bit ap, input bit rd, input bit [1:0] a,
                         input logic [DW-1:0] wd, input bit hold, output int cyc);
        obs_hdr.delete(); obs_wd.delete();
        cyc = 0;
        @(negedge clk);
        cmd_valid = 1; cmd_ap = ap; cmd_read = rd; cmd_addr = a; cmd_wdata = wd;
        @(negedge clk);
        if (hold) begin cmd_ap = 0; cmd_read = 0; cmd_addr = 2'd2; cmd_wdata = 32'hDEAD; end
        else cmd_valid = 0;
        chk(busy === 1'b1, "R12 busy after accept", {31'd0, busy}, 32'd1);
        cyc = 1;
        while (!rsp_valid && cyc < 1000) begin @(negedge clk); cyc++; end
        cmd_valid = 0;
    endtask

    task automatic run(input string tag, input bit ap, input bit rd, input bit [1:0] a,
                       input logic [DW-1:0] wd, input bit hold);
        int cyc;
        model(ap, rd, a, wd);
        issue(ap, rd, a, wd, hold, cyc);
        chk(rsp_valid === 1'b1, {tag, " result strobe"}, {31'd0, rsp_valid}, 32'd1);
        chk(rsp_status === exp_status, {tag, " status"}, {29'd0, rsp_status}, {29'd0, exp_status});
        chk(rsp_data === exp_data, {tag, " data"}, rsp_data, exp_data);
        chk(obs_hdr.size() == exp_hdr.size(), {tag, " packet count"}, obs_hdr.size(), exp_hdr.size());
        for (int i = 0; i < exp_hdr.size() && i < obs_hdr.size(); i++) begin
            chk(obs_hdr[i] === exp_hdr[i], {tag, " header"}, {24'd0, obs_hdr[i]}, {24'd0, exp_hdr[i]});
            chk(obs_wd[i] === exp_wd[i], {tag, " write word"}, obs_wd[i], exp_wd[i]);
        end
        @(negedge clk);
        chk(busy === 1'b0, "R12 busy drops after strobe", {31'd0, busy}, 32'd0);
        chk(fault_flag === m_fault, {tag, " fault flag"}, {31'd0, fault_flag}, {31'd0, m_fault});
        e_ack.delete(); e_rd.delete(); e_pe.delete();
        m_ack.delete(); m_rd.delete(); m_pe.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int cyc;
        bit same;
        repeat (3) @(negedge clk);
        // R13: reset state
        chk(busy === 0 && rsp_valid === 0 && pkt_req === 0 && fault_flag === 0,
            "R13 reset outputs", {28'd0, busy, rsp_valid, pkt_req, fault_flag}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy === 0 && pkt_req === 0, "R13 idle after reset", {30'd0, busy, pkt_req}, 32'd0);

        // R1 R2: DP read, header 0xA5
        resp(3'b001, 32'h2BA01477, 0);
        run("R1 R2 dp read", 0, 1, 2'd0, '0, 0);
        // R2: DP write
        resp(3'b001, '0, 0);
        run("R2 dp write", 0, 0, 2'd2, 32'h000000F0, 0);
        // R3: posted AP read
        resp(3'b001, 32'h11, 0); resp(3'b001, 32'hCAFE0001, 0);
        run("R3 ap read", 1, 1, 2'd1, '0, 0);
        // R4 R12: WAITs then OK, cmd_valid held during busy
        resp(3'b010, '0, 0); resp(3'b010, '0, 0); resp(3'b001, '0, 0);
        run("R4 R12 ap write wait", 1, 0, 2'd0, 32'h000055AA, 1);
        // R3 R4: WAIT on both halves of a posted read
        resp(3'b010, '0, 0); resp(3'b001, 32'h5, 0);
        resp(3'b010, '0, 0); resp(3'b001, 32'h9, 0);
        run("R3 R4 ap read wait", 1, 1, 2'd2, '0, 0);
        // R6 R7: FAULT, all four sticky flags, replay succeeds
        resp(3'b100, '0, 0); resp(3'b001, 32'h000000B2, 0); resp(3'b001, '0, 0);
        resp(3'b001, 32'h1234, 0);
        run("R6 R7 dp fault recover", 0, 1, 2'd1, '0, 0);
        // R7 R8: overrun only, replay faults again
        resp(3'b100, '0, 0); resp(3'b001, 32'h00000002, 0); resp(3'b001, '0, 0);
        resp(3'b100, '0, 0);
        run("R7 R8 ap fault latch", 1, 1, 2'd3, '0, 0);
        // R9: AP blocked while latched
        run("R9 ap blocked", 1, 0, 2'd1, 32'h77, 0);
        // R7 R9: DP still runs; its recovery clears the flag (status read fails parity)
        resp(3'b100, '0, 0); resp(3'b001, 32'h000000FF, 1); resp(3'b001, '0, 0);
        resp(3'b001, 32'h77, 0);
        run("R7 R9 dp clears fault", 0, 1, 2'd0, '0, 0);
        // R11: parity error on the read-buffer half
        resp(3'b001, 32'h1, 0); resp(3'b001, 32'hFFFF, 1);
        run("R11 rdbuf parity", 1, 1, 2'd0, '0, 0);
        // R11: parity error on a DP read
        resp(3'b001, 32'h3, 1);
        run("R11 dp parity", 0, 1, 2'd2, '0, 0);
        // R10: invalid acknowledge
        resp(3'b111, 32'h3, 0);
        run("R10 bad ack", 0, 1, 2'd0, '0, 0);
        resp(3'b000, '0, 0);
        run("R10 zero ack", 0, 0, 2'd1, 32'h1, 0);

        // R5: endless WAIT runs into the budget
        issue(0, 1, 2'd2, '0, 0, cyc);
        chk(rsp_status === 3'd2, "R5 timeout status", {29'd0, rsp_status}, 32'd2);
        chk(rsp_data === '0, "R5 timeout data", rsp_data, '0);
        chk(cyc >= TMO && cyc <= TMO + 8, "R5 timeout latency", cyc, TMO);
        same = 1;
        foreach (obs_hdr[i]) if (obs_hdr[i] !== mk_hdr(0, 1, 2'd2)) same = 0;
        chk(same && obs_hdr.size() > 4, "R4 R5 wait reissue headers", obs_hdr.size(), 5);
        @(negedge clk);
        chk(busy === 0, "R12 idle after timeout", {31'd0, busy}, 32'd0);

        repeat (3) @(negedge clk);
        summary();
    end

endmodule